// File: doc/BRIEF.md
# Segment Register Load Unit

On a virtual-machine entry the processor has to commit the hidden part of eight segment registers: the code, stack, four data segments, the task register and the local descriptor table register. Each register's state comes from the guest-state area as a selector, a base, a limit and an access-rights word. Whether most of these fields are committed depends on an unusable flag carried in the access-rights word. Some fields are exceptions to that rule and are always committed.

The block samples the guest fields on the cycle `loadEn` is high and commits them one clock later. A field that is skipped keeps its previous contents, and that stands in for an undefined value. The LDTR base is the one exception: when it is skipped it is forced to zero so that it stays canonical. The block exposes the committed state of every register, a per-register unusable flag for the downstream fault logic, and the current privilege level taken from the stack segment.

Register slot order in every packed port is fixed: 0 CS, 1 SS, 2 DS, 3 ES, 4 FS, 5 GS, 6 TR, 7 LDTR. The access-rights word is 13 bits wide:
- bits 3:0 type
- bit 4 S
- bits 6:5 DPL
- bit 7 P
- bit 8 AVL
- bit 9 L
- bit 10 D
- bit 11 G
- bit 12 unusable

Top module: `segLoadUnit`

## Requirements
- R1: While `rstN` is low, every selector, base, limit and access-rights output, every `segUnusable` bit and `cpl` read 0.
- R2: Outputs change only on the clock edge that samples `loadEn` high. A cycle with `loadEn` low leaves every output unchanged, whatever the guest inputs carry.
- R3: Every selector is committed on each load, whatever its unusable flag is.
- R4: CS base, limit and access bits 11:9 (G, D, L) are always committed. CS access bits 8:0 are committed only when its unusable flag (bit 12) is 0.
- R5: For SS, DS, ES, FS, GS and LDTR, the limit and access bits 11:0 are committed only when the unusable flag is 0. Otherwise they keep their old values, except for the fields named in R6.
- R6: The SS DPL field (access bits 6:5) is always committed, and `cpl` equals the committed SS DPL.
- R7: The FS and GS bases are always committed in full, even when those registers are unusable.
- R8: SS, DS and ES bases are committed only when usable, and their upper half (bits 63:32) is then written as 0.
- R9: TR ignores its unusable flag. Its selector, base, limit and access bits 11:0 are always committed, and its committed unusable bit (`segUnusable[6]`, access bit 12) is always 0.
- R10: When LDTR is unusable on a load, its base becomes 0.
- R11: On each load, `segUnusable[i]` and committed access bit 12 take the sampled unusable flag of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Commit the guest fields on this edge |
| guestSel | input | 128 | Guest selectors, 16 bits per slot |
| guestBase | input | 512 | Guest bases, 64 bits per slot |
| guestLimit | input | 256 | Guest limits, 32 bits per slot |
| guestAr | input | 104 | Guest access-rights words, 13 bits per slot |
| segSel | output | 128 | Committed selectors |
| segBase | output | 512 | Committed bases |
| segLimit | output | 256 | Committed limits |
| segAr | output | 104 | Committed access-rights words |
| segUnusable | output | 8 | Committed unusable flag per slot |
| cpl | output | 2 | Current privilege level (SS DPL) |

## Verification
The bench targets the following corner cases:
- **Unusable CS.** It must update only G, D and L. A design that gates the whole word would leave stale G/D/L bits; one that ignores the flag would overwrite the type and DPL bits.
- **Unusable SS.** It must still move `cpl`. The bench also checks that the SS, DS and ES base upper halves come out as zero.
- **Unusable FS and GS.** Their bases must still be committed.
- **TR with its flag set.** TR must load fully and report usable.
- **Unusable LDTR.** Its base must zero rather than hold. Design errors on this path show up as a stale LDTR base or a nonzero TR unusable bit.
- **Idle cycles with changing inputs.** These expose any path that commits without `loadEn`.

// File: rtl/segLoadPkg.sv
package segLoadPkg;
  localparam int NSEG = 8;
  localparam int AR_W = 13;

  localparam int IDX_CS   = 0;
  localparam int IDX_SS   = 1;
  localparam int IDX_DS   = 2;
  localparam int IDX_ES   = 3;
  localparam int IDX_FS   = 4;
  localparam int IDX_GS   = 5;
  localparam int IDX_TR   = 6;
  localparam int IDX_LDTR = 7;

  localparam int AR_DPL_LO = 5;
  localparam int AR_L      = 9;
  localparam int AR_D      = 10;
  localparam int AR_G      = 11;
  localparam int AR_UNUS   = 12;

  typedef struct packed {
    logic selWe;
    logic baseWe;
    logic baseZero;
    logic limWe;
    logic arFullWe;
    logic arFixedWe;
    logic unusWe;
    logic unusVal;
  } segStrobe_t;

  // access bits committed regardless of the unusable flag
  function automatic logic [AR_W-1:0] fixedArMask(input int idx);
    logic [AR_W-1:0] m;
    m = '0;
    if (idx == IDX_CS) begin
      m[AR_L] = 1'b1;
      m[AR_D] = 1'b1;
      m[AR_G] = 1'b1;
    end else if (idx == IDX_SS) begin
      m[AR_DPL_LO]   = 1'b1;
      m[AR_DPL_LO+1] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/segLoadCtrl.sv
module segLoadCtrl
  import segLoadPkg::*;
(
  input  logic                       loadEn,
  input  logic [NSEG-1:0]            unusReq,
  output segStrobe_t [NSEG-1:0]      strb
);
  for (genvar i = 0; i < NSEG; i++) begin : g_ctrl
    logic unus;
    assign unus = (i == IDX_TR) ? 1'b0 : unusReq[i];

    always_comb begin
      strb[i] = '0;
      if (loadEn) begin
        strb[i].selWe   = 1'b1;
        strb[i].unusWe  = 1'b1;
        strb[i].unusVal = unus;
        strb[i].limWe   = !unus;
        strb[i].arFullWe = !unus;
        strb[i].baseWe  = !unus;
        case (i)
          IDX_CS: begin
            strb[i].baseWe    = 1'b1;
            strb[i].limWe     = 1'b1;
            strb[i].arFixedWe = 1'b1;
          end
          IDX_SS: strb[i].arFixedWe = 1'b1;
          IDX_FS, IDX_GS: strb[i].baseWe = 1'b1;
          IDX_LDTR: strb[i].baseZero = unus;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/segLoadData.sv
module segLoadData
  import segLoadPkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  segStrobe_t [NSEG-1:0]             strb,
  input  logic [NSEG-1:0][SEL_W-1:0]        inSel,
  input  logic [NSEG-1:0][BASE_W-1:0]       inBase,
  input  logic [NSEG-1:0][LIM_W-1:0]        inLimit,
  input  logic [NSEG-1:0][AR_W-1:0]         inAr,
  output logic [NSEG-1:0][SEL_W-1:0]        selQ,
  output logic [NSEG-1:0][BASE_W-1:0]       baseQ,
  output logic [NSEG-1:0][LIM_W-1:0]        limQ,
  output logic [NSEG-1:0][AR_W-1:0]         arQ
);
  localparam int HALF_W = BASE_W / 2;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam bit CLR_HIGH = (i == IDX_SS) || (i == IDX_DS) || (i == IDX_ES);
    localparam logic [AR_W-1:0] FIX_MASK = fixedArMask(i);

    logic [BASE_W-1:0] baseIn;
    logic [AR_W-1:0]   arNext;

    if (CLR_HIGH) begin : g_clr
      assign baseIn = {{(BASE_W-HALF_W){1'b0}}, inBase[i][HALF_W-1:0]};
    end else begin : g_full
      assign baseIn = inBase[i];
    end

    always_comb begin
      arNext = arQ[i];
      if (strb[i].arFullWe)
        arNext = inAr[i];
      else if (strb[i].arFixedWe)
        arNext = (arQ[i] & ~FIX_MASK) | (inAr[i] & FIX_MASK);
      if (strb[i].unusWe)
        arNext[AR_UNUS] = strb[i].unusVal;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        selQ[i]  <= '0;
        baseQ[i] <= '0;
        limQ[i]  <= '0;
        arQ[i]   <= '0;
      end else begin
        if (strb[i].selWe)    selQ[i]  <= inSel[i];
        if (strb[i].baseZero) baseQ[i] <= '0;
        else if (strb[i].baseWe) baseQ[i] <= baseIn;
        if (strb[i].limWe)    limQ[i]  <= inLimit[i];
        arQ[i] <= arNext;
      end
    end
  end
endmodule

// File: rtl/segLoadUnit.sv
module segLoadUnit
  import segLoadPkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic [NSEG*SEL_W-1:0]    guestSel,
  input  logic [NSEG*BASE_W-1:0]   guestBase,
  input  logic [NSEG*LIM_W-1:0]    guestLimit,
  input  logic [NSEG*AR_W-1:0]     guestAr,
  output logic [NSEG*SEL_W-1:0]    segSel,
  output logic [NSEG*BASE_W-1:0]   segBase,
  output logic [NSEG*LIM_W-1:0]    segLimit,
  output logic [NSEG*AR_W-1:0]     segAr,
  output logic [NSEG-1:0]          segUnusable,
  output logic [1:0]               cpl
);
  segStrobe_t [NSEG-1:0]      strb;
  logic [NSEG-1:0]            unusReq;
  logic [NSEG-1:0][AR_W-1:0]  arQ;

  for (genvar i = 0; i < NSEG; i++) begin : g_top
    assign unusReq[i]     = guestAr[i*AR_W + AR_UNUS];
    assign segUnusable[i] = arQ[i][AR_UNUS];
  end

  segLoadCtrl u_ctrl (
    .loadEn (loadEn),
    .unusReq(unusReq),
    .strb   (strb)
  );

  segLoadData #(.SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inSel  (guestSel),
    .inBase (guestBase),
    .inLimit(guestLimit),
    .inAr   (guestAr),
    .selQ   (segSel),
    .baseQ  (segBase),
    .limQ   (segLimit),
    .arQ    (arQ)
  );

  assign segAr = arQ;
  assign cpl   = arQ[IDX_SS][AR_DPL_LO +: 2];
endmodule

// File: rtl/segLoadChk.sv
module segLoadChk
  import segLoadPkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int BASE_W = 64,
  parameter int LIM_W  = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    loadEn,
  input logic [NSEG*SEL_W-1:0]   guestSel,
  input logic [NSEG*BASE_W-1:0]  guestBase,
  input logic [NSEG*AR_W-1:0]    guestAr,
  input logic [NSEG*SEL_W-1:0]   segSel,
  input logic [NSEG*BASE_W-1:0]  segBase,
  input logic [NSEG*LIM_W-1:0]   segLimit,
  input logic [NSEG*AR_W-1:0]    segAr,
  input logic [NSEG-1:0]         segUnusable,
  input logic [1:0]              cpl
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> ($stable(segSel) && $stable(segBase) && $stable(segLimit) && $stable(segAr)));

  // R3
  sel_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> segSel == $past(guestSel));

  // R6
  cpl_follows_ss_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> cpl == $past(guestAr[IDX_SS*AR_W + AR_DPL_LO +: 2]));

  // R7
  fs_base_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> segBase[IDX_FS*BASE_W +: BASE_W] == $past(guestBase[IDX_FS*BASE_W +: BASE_W]));

  // R9
  tr_never_unusable_chk: assert property (@(posedge clk) disable iff (!rstN)
    segUnusable[IDX_TR] == 1'b0);

  // R10
  ldtr_base_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && guestAr[IDX_LDTR*AR_W + AR_UNUS]) |=> segBase[IDX_LDTR*BASE_W +: BASE_W] == '0);
endmodule

bind segLoadUnit segLoadChk #(.SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .guestSel(guestSel), .guestBase(guestBase),
  .guestAr(guestAr), .segSel(segSel), .segBase(segBase), .segLimit(segLimit),
  .segAr(segAr), .segUnusable(segUnusable), .cpl(cpl)
);

// File: tb/tb_segLoadUnit.sv
module tb_segLoadUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0;
  logic [7:0][15:0] gSel;
  logic [7:0][63:0] gBase;
  logic [7:0][31:0] gLim;
  logic [7:0][12:0] gAr;
  logic [7:0][15:0] oSel;
  logic [7:0][63:0] oBase;
  logic [7:0][31:0] oLim;
  logic [7:0][12:0] oAr;
  logic [7:0]       oUnus;
  logic [1:0]       oCpl;

  logic [15:0] mSel [8];
  logic [63:0] mBase [8];
  logic [31:0] mLim [8];
  logic [12:0] mAr [8];

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  segLoadUnit dut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn),
    .guestSel(gSel), .guestBase(gBase), .guestLimit(gLim), .guestAr(gAr),
    .segSel(oSel), .segBase(oBase), .segLimit(oLim), .segAr(oAr),
    .segUnusable(oUnus), .cpl(oCpl)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin
        mSel[i] <= '0; mBase[i] <= '0; mLim[i] <= '0; mAr[i] <= '0;
      end
    end else if (loadEn) begin
      for (int i = 0; i < 8; i++) begin
        logic u;
        logic [12:0] a;
        u = (i == 6) ? 1'b0 : gAr[i][12];
        a = mAr[i];
        mSel[i] <= gSel[i];
        if (i == 0) begin
          mBase[i] <= gBase[i];
          mLim[i]  <= gLim[i];
          if (!u) a = gAr[i];
          else a[11:9] = gAr[i][11:9];
        end else if (i == 6) begin
          mBase[i] <= gBase[i];
          mLim[i]  <= gLim[i];
          a = gAr[i];
        end else begin
          if (i == 4 || i == 5) mBase[i] <= gBase[i];
          else if (!u) mBase[i] <= (i <= 3) ? {32'h0, gBase[i][31:0]} : gBase[i];
          else if (i == 7) mBase[i] <= '0;
          if (!u) begin
            mLim[i] <= gLim[i];
            a = gAr[i];
          end else if (i == 1) a[6:5] = gAr[i][6:5];
        end
        a[12] = u;
        mAr[i] <= a;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string baseTag(input int i);
    case (i)
      0: return "R4";
      1, 2, 3: return "R8";
      4, 5: return "R7";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compareAll(input bit inReset);
    for (int i = 0; i < 8; i++) begin
      chk(inReset ? "R1" : "R3", $sformatf("sel[%0d]", i), 64'(oSel[i]), 64'(mSel[i]));
      chk(inReset ? "R1" : baseTag(i), $sformatf("base[%0d]", i), oBase[i], mBase[i]);
      chk(inReset ? "R1" : (i == 0 ? "R4" : (i == 6 ? "R9" : "R5")),
          $sformatf("limit[%0d]", i), 64'(oLim[i]), 64'(mLim[i]));
      chk(inReset ? "R1" : (i == 0 ? "R4" : (i == 1 ? "R6" : (i == 6 ? "R9" : "R5"))),
          $sformatf("ar[%0d]", i), 64'(oAr[i][11:0]), 64'(mAr[i][11:0]));
      chk(inReset ? "R1" : "R11", $sformatf("unusable[%0d]", i), 64'(oUnus[i]), 64'(mAr[i][12]));
    end
    chk(inReset ? "R1" : "R6", "cpl", 64'(oCpl), 64'(mAr[1][6:5]));
  endtask

  task automatic drive(input bit en, input logic [7:0] unusMask);
    loadEn = en;
    for (int i = 0; i < 8; i++) begin
      gSel[i]  = 16'($urandom);
      gBase[i] = {$urandom, $urandom};
      gLim[i]  = $urandom;
      gAr[i]   = {unusMask[i], 12'($urandom)};
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0][15:0] snapSel;
    logic [7:0][63:0] snapBase;
    drive(1'b1, 8'hFF);
    repeat (3) @(negedge clk);
    compareAll(1'b1);                       // R1 reset values
    rstN = 1'b1;
    drive(1'b1, 8'h00);                     // all usable
    @(negedge clk); compareAll(1'b0);
    drive(1'b1, 8'hFF);                     // all unusable, TR flag set too
    @(negedge clk); compareAll(1'b0);
    drive(1'b1, 8'h00);
    @(negedge clk); compareAll(1'b0);
    drive(1'b1, 8'hBF);                     // all unusable except TR
    @(negedge clk); compareAll(1'b0);
    // R2: idle cycles with changing inputs must not move outputs
    snapSel = oSel; snapBase = oBase;
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 8'($urandom));
      @(negedge clk);
      compareAll(1'b0);
    end
    for (int i = 0; i < 8; i++) begin
      chk("R2", $sformatf("held sel[%0d]", i), 64'(oSel[i]), 64'(snapSel[i]));
      chk("R2", $sformatf("held base[%0d]", i), oBase[i], snapBase[i]);
    end
    for (int k = 0; k < 300; k++) begin
      drive(($urandom % 4) != 0, 8'($urandom));
      @(negedge clk);
      compareAll(1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule